// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block is a fixed-point multiply-accumulate datapath for filter kernels. Each cycle it may take one command together with two signed 16-bit operands. It forms their full 32-bit product and adds it to, subtracts it from, or loads it into a private 40-bit accumulator. The 8 guard bits above the product range let a run of full-scale products grow past 32 bits and come back without losing information. The accumulator only adds and subtracts. It never clamps.

A separate writeback command reads the accumulator through an arithmetic right shifter. It then either saturates or truncates the shifted value to a 32-bit or a 16-bit destination and presents the registered result one cycle later. A sticky flag records every clamp. A second sticky flag records any wrap of the 40-bit accumulator itself. One command clears both flags.

Top module: `mac_sat_unit`

## Requirements
- R1: After synchronous reset the accumulator holds zero, `res_data` is 0, and `res_valid`, `sat_flag` and `ovf_flag` are all 0.
- R2: Command code 2 (accumulate) adds the signed product `opnd_a*opnd_b` to the accumulator at the clock edge that accepts it. A writeback issued in the next cycle sees the new value, so accumulate commands can issue back to back.
- R3: Command code 3 (deduct) subtracts the signed product from the accumulator at the accepting edge.
- R4: Command code 1 loads zero into the accumulator. Command code 6 loads the product directly, discarding the old value. Codes 0 and 7 do nothing.
- R5: The accumulator is 40 bits wide. A sequence of products whose intermediate sums exceed the 32-bit range but whose final sum fits returns the exact final sum.
- R6: Command code 4 (writeback) leaves the accumulator unchanged. It raises `res_valid` for exactly the cycle after it is accepted, with the result on `res_data`. In all other cycles `res_valid` is 0.
- R7: Writeback first shifts the accumulator right arithmetically by `wb_shift` (0 to 31). The range test and the result both use the shifted value.
- R8: With `wb_sat`=1 and `wb_wide`=1, a shifted value outside the signed 32-bit range gives 0x7FFFFFFF or 0x80000000, according to its sign.
- R9: With `wb_wide`=0 the destination is 16 bits. The result is sign-extended to 32 bits on `res_data`. Saturation gives 0x00007FFF or 0xFFFF8000.
- R10: With `wb_sat`=0 the writeback truncates to the low 32 bits (wide) or to the low 16 bits, sign-extended (narrow), so out-of-range values wrap.
- R11: `sat_flag` sets at the edge of any writeback that clamps. It stays set until command code 5 clears it at its accepting edge.
- R12: `ovf_flag` sets when an accumulate, deduct or load leaves the signed 40-bit range. It stays set until command code 5 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 3 | Command code, one per cycle |
| opnd_a | input | 16 | Signed multiplicand |
| opnd_b | input | 16 | Signed multiplier |
| wb_shift | input | 5 | Arithmetic right shift for writeback |
| wb_wide | input | 1 | 1: 32-bit destination, 0: 16-bit destination |
| wb_sat | input | 1 | 1: saturate on writeback, 0: truncate |
| res_data | output | 32 | Registered writeback result |
| res_valid | output | 1 | High the cycle after a writeback |
| sat_flag | output | 1 | Sticky clamp indicator |
| ovf_flag | output | 1 | Sticky accumulator wrap indicator |

## Verification
Accumulator commands take effect at the edge that accepts them. A writeback's data, its valid pulse and any flag change appear at that same edge and are visible for the following cycle. The bench therefore drives each command just after a rising edge. It waits for the next edge and a short settle, then compares outputs against a reference model that it has also advanced by one command. The accumulator is observed only through writebacks, which carry a zero or chosen shift.

// File: rtl/mac_pkg.sv
package mac_pkg;

    localparam int OPW   = 16;
    localparam int GUARD = 8;
    localparam int PRODW = 2 * OPW;
    localparam int ACCW  = PRODW + GUARD;
    localparam int RESW  = PRODW;
    localparam int SHW   = $clog2(RESW);

    typedef enum logic [2:0] {
        C_NOP  = 3'd0,
        C_ZERO = 3'd1,
        C_ACC  = 3'd2,
        C_DED  = 3'd3,
        C_WB   = 3'd4,
        C_FCLR = 3'd5,
        C_LOAD = 3'd6,
        C_RSV  = 3'd7
    } cmd_e;

    typedef struct packed {
        logic [SHW-1:0] shift;
        logic           wide;
        logic           sat;
    } wb_cfg_t;

    typedef struct packed {
        logic [RESW-1:0] data;
        logic            clamped;
    } wb_out_t;

    function automatic logic fits_signed(input logic [ACCW-1:0] v, input int bits);
        logic all1, all0;
        all1 = 1'b1;
        all0 = 1'b1;
        for (int i = 0; i < ACCW; i++) begin
            if (i >= bits - 1) begin
                all1 &= v[i];
                all0 &= ~v[i];
            end
        end
        return all1 | all0;
    endfunction

    function automatic logic [ACCW-1:0] sext_prod(input logic [PRODW-1:0] p);
        return {{GUARD{p[PRODW-1]}}, p};
    endfunction

endpackage

// File: rtl/mac_mult.sv
module mac_mult
    import mac_pkg::*;
#(
    parameter int W = OPW
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] prod
);
    always_comb begin
        prod = $signed(a) * $signed(b);
    end
endmodule

// File: rtl/mac_accum.sv
module mac_accum
    import mac_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  cmd_e             cmd,
    input  logic [PRODW-1:0] prod,
    output logic [ACCW-1:0]  acc,
    output logic             ovf
);
    logic [ACCW-1:0] pext, nxt;
    logic            wrap;

    always_comb begin
        pext = sext_prod(prod);
        nxt  = acc;
        wrap = 1'b0;
        unique case (cmd)
            C_ZERO: nxt = '0;
            C_LOAD: nxt = pext;
            C_ACC: begin
                nxt  = acc + pext;
                wrap = (acc[ACCW-1] == pext[ACCW-1]) && (nxt[ACCW-1] != acc[ACCW-1]);
            end
            C_DED: begin
                nxt  = acc - pext;
                wrap = (acc[ACCW-1] != pext[ACCW-1]) && (nxt[ACCW-1] != acc[ACCW-1]);
            end
            default: nxt = acc;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
            ovf <= 1'b0;
        end else begin
            acc <= nxt;
            if (cmd == C_FCLR) ovf <= 1'b0;
            else if (wrap)     ovf <= 1'b1;
        end
    end

    AST_ACC_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cmd == C_ZERO) |=> (acc == '0)); // R4
    AST_ACC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cmd inside {C_NOP, C_WB, C_FCLR, C_RSV}) |=> $stable(acc)); // R6
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ovf && cmd != C_FCLR) |=> ovf); // R12
    AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (cmd == C_FCLR) |=> !ovf); // R12
endmodule

// File: rtl/mac_writeback.sv
module mac_writeback
    import mac_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  cmd_e            cmd,
    input  wb_cfg_t         cfg,
    input  logic [ACCW-1:0] acc,
    output logic [RESW-1:0] data,
    output logic            valid,
    output logic            sat
);
    logic [ACCW-1:0] shifted;
    wb_out_t         wo;
    logic            in_rng;
    logic            wide_q;

    always_comb begin
        shifted = $signed(acc) >>> cfg.shift;
        in_rng  = cfg.wide ? fits_signed(shifted, RESW) : fits_signed(shifted, OPW);
        wo      = '0;
        if (!in_rng && cfg.sat) begin
            wo.clamped = 1'b1;
            if (cfg.wide)
                wo.data = shifted[ACCW-1] ? {1'b1, {(RESW-1){1'b0}}} : {1'b0, {(RESW-1){1'b1}}};
            else
                wo.data = shifted[ACCW-1] ? {{(RESW-OPW+1){1'b1}}, {(OPW-1){1'b0}}}
                                          : {{(RESW-OPW+1){1'b0}}, {(OPW-1){1'b1}}};
        end else if (cfg.wide) begin
            wo.data = shifted[RESW-1:0];
        end else begin
            wo.data = {{(RESW-OPW){shifted[OPW-1]}}, shifted[OPW-1:0]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data   <= '0;
            valid  <= 1'b0;
            sat    <= 1'b0;
            wide_q <= 1'b1;
        end else begin
            valid <= (cmd == C_WB);
            if (cmd == C_WB) begin
                data   <= wo.data;
                wide_q <= cfg.wide;
            end
            if (cmd == C_FCLR)                 sat <= 1'b0;
            else if (cmd == C_WB && wo.clamped) sat <= 1'b1;
        end
    end

    AST_WB_PULSE: assert property (@(posedge clk) disable iff (rst)
        (cmd == C_WB) |=> valid); // R6
    AST_WB_QUIET: assert property (@(posedge clk) disable iff (rst)
        (cmd != C_WB) |=> !valid); // R6
    AST_NARROW_SEXT: assert property (@(posedge clk) disable iff (rst)
        (valid && !wide_q) |-> (data[RESW-1:OPW] == {(RESW-OPW){data[OPW-1]}})); // R9
    AST_SAT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (sat && cmd != C_FCLR) |=> sat); // R11
    AST_SAT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (cmd == C_FCLR) |=> !sat); // R11
    AST_SAT_ONLY_WB: assert property (@(posedge clk) disable iff (rst)
        (!sat && cmd != C_WB) |=> !sat); // R11
endmodule

// File: rtl/mac_sat_unit.sv
module mac_sat_unit
    import mac_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [2:0]      cmd,
    input  logic [OPW-1:0]  opnd_a,
    input  logic [OPW-1:0]  opnd_b,
    input  logic [SHW-1:0]  wb_shift,
    input  logic            wb_wide,
    input  logic            wb_sat,
    output logic [RESW-1:0] res_data,
    output logic            res_valid,
    output logic            sat_flag,
    output logic            ovf_flag
);
    cmd_e             c;
    wb_cfg_t          cfg;
    logic [PRODW-1:0] prod;
    logic [ACCW-1:0]  acc;

    assign c   = cmd_e'(cmd);
    assign cfg = '{shift: wb_shift, wide: wb_wide, sat: wb_sat};

    mac_mult #(.W(OPW)) u_mult (
        .a    (opnd_a),
        .b    (opnd_b),
        .prod (prod)
    );

    mac_accum u_acc (
        .clk  (clk),
        .rst  (rst),
        .cmd  (c),
        .prod (prod),
        .acc  (acc),
        .ovf  (ovf_flag)
    );

    mac_writeback u_wb (
        .clk   (clk),
        .rst   (rst),
        .cmd   (c),
        .cfg   (cfg),
        .acc   (acc),
        .data  (res_data),
        .valid (res_valid),
        .sat   (sat_flag)
    );

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (!res_valid && !sat_flag && !ovf_flag && res_data == '0)); // R1
endmodule

// File: tb/tb_mac_sat_unit.sv
module tb_mac_sat_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  cmd = 3'd0;
    logic [15:0] opnd_a = '0, opnd_b = '0;
    logic [4:0]  wb_shift = '0;
    logic        wb_wide = 1'b1, wb_sat = 1'b0;
    logic [31:0] res_data;
    logic        res_valid, sat_flag, ovf_flag;

    int  checks = 0, errors = 0;
    bit  done = 0;

    longint m_acc = 0;
    bit     m_sat = 0, m_ovf = 0;

    always #5 clk = ~clk;

    mac_sat_unit dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic longint wrap40(input longint v);
        return (v <<< 24) >>> 24;
    endfunction

    function automatic void wb_model(input longint a, input int sh, input bit wide, input bit sat,
                                     output logic [31:0] r, output bit clamp);
        longint s, hi, lo;
        s  = a >>> sh;
        hi = wide ? 64'sd2147483647 : 64'sd32767;
        lo = -hi - 1;
        clamp = 0;
        if (s > hi || s < lo) begin
            if (sat) begin
                clamp = 1;
                r = (s > hi) ? hi[31:0] : lo[31:0];
            end else begin
                r = wide ? s[31:0] : {{16{s[15]}}, s[15:0]};
            end
        end else begin
            r = s[31:0];
        end
    endfunction

    // Drive one command, wait one edge, update the model, compare.
    task automatic issue(input string req, input logic [2:0] op, input logic [15:0] a, input logic [15:0] b,
                         input int sh, input bit wide, input bit sat);
        longint p, t;
        logic [31:0] er;
        bit cl;
        er = 'x;
        cmd = op; opnd_a = a; opnd_b = b; wb_shift = sh[4:0]; wb_wide = wide; wb_sat = sat;
        @(posedge clk);
        #1;
        p = longint'($signed(a)) * longint'($signed(b));
        case (op)
            3'd1: m_acc = 0;
            3'd2: begin t = m_acc + p; if (t != wrap40(t)) m_ovf = 1; m_acc = wrap40(t); end
            3'd3: begin t = m_acc - p; if (t != wrap40(t)) m_ovf = 1; m_acc = wrap40(t); end
            3'd4: begin wb_model(m_acc, sh, wide, sat, er, cl); if (cl) m_sat = 1; end
            3'd5: begin m_sat = 0; m_ovf = 0; end
            3'd6: m_acc = p;
            default: ;
        endcase
        chk("R6 res_valid", {31'd0, res_valid}, {31'd0, op == 3'd4});
        if (op == 3'd4) chk(req, res_data, er);
        chk("R11 sat_flag", {31'd0, sat_flag}, {31'd0, m_sat});
        chk("R12 ovf_flag", {31'd0, ovf_flag}, {31'd0, m_ovf});
        cmd = 3'd0;
    endtask

    task automatic wb(input string req, input int sh, input bit wide, input bit sat);
        issue(req, 3'd4, 16'd0, 16'd0, sh, wide, sat);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset state
        chk("R1 res_data", res_data, 32'd0);
        chk("R1 res_valid", {31'd0, res_valid}, 32'd0);
        chk("R1 flags", {30'd0, sat_flag, ovf_flag}, 32'd0);
        wb("R1 accumulator zero", 0, 1, 1);

        // R4 load product, R2 back-to-back accumulate, guard bits
        issue("R4 load", 3'd6, 16'h7FFF, 16'h7FFF, 0, 1, 0);
        wb("R4 load product", 0, 1, 1);
        repeat (3) issue("R2 mac", 3'd2, 16'h7FFF, 16'h7FFF, 0, 1, 0);
        wb("R8 wide clamp positive", 0, 1, 1);
        wb("R10 wide truncation", 0, 1, 0);
        wb("R7 shifted into range", 2, 1, 1);
        issue("R11 clear flags", 3'd5, 0, 0, 0, 1, 0);
        repeat (3) issue("R3 deduct", 3'd3, 16'h7FFF, 16'h7FFF, 0, 1, 0);
        wb("R5 guard bits exact", 0, 1, 1);
        wb("R9 narrow in range", 16, 0, 1);
        wb("R9 narrow clamp positive", 8, 0, 1);
        wb("R10 narrow truncation", 8, 0, 0);
        issue("R4 load negative", 3'd6, 16'h8000, 16'h7FFF, 0, 1, 0);
        wb("R9 narrow clamp negative", 0, 0, 1);
        wb("R7 shift 31", 31, 0, 1);
        issue("R4 zero", 3'd1, 0, 0, 0, 1, 0);
        issue("R4 reserved nop", 3'd7, 16'h1234, 16'h5678, 0, 1, 0);
        wb("R4 zero then nop", 0, 1, 1);
        issue("R3 deduct negative", 3'd3, 16'h8000, 16'h8000, 0, 1, 0);
        repeat (3) issue("R3 deduct", 3'd3, 16'h8000, 16'h8000, 0, 1, 0);
        wb("R8 wide clamp negative", 0, 1, 1);
        issue("R11 clear", 3'd5, 0, 0, 0, 1, 0);

        // R12 drive accumulator past 40-bit range
        issue("R4 zero", 3'd1, 0, 0, 0, 1, 0);
        for (int i = 0; i < 512; i++) issue("R12 grow", 3'd2, 16'h8000, 16'h8000, 0, 1, 0);
        wb("R12 wrapped value", 8, 1, 0);
        issue("R12 clear", 3'd5, 0, 0, 0, 1, 0);

        // Random mix: R2 R3 R7 R8 R9 R10
        issue("R4 zero", 3'd1, 0, 0, 0, 1, 0);
        for (int i = 0; i < 4000; i++) begin
            int sel;
            logic [2:0] op;
            sel = $urandom_range(0, 99);
            if (sel < 35)      op = 3'd2;
            else if (sel < 60) op = 3'd3;
            else if (sel < 88) op = 3'd4;
            else if (sel < 92) op = 3'd6;
            else if (sel < 95) op = 3'd1;
            else if (sel < 98) op = 3'd5;
            else               op = 3'd0;
            issue("R2 R3 R7 random writeback", op, 16'($urandom), 16'($urandom),
                  $urandom_range(0, 31), 1'($urandom), 1'($urandom));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule